// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter of a small processor and chooses the next fetch address on every rising clock edge. It watches the opcode of the instruction now executing, a signed branch offset, an unsigned jump offset and an equality flag that the datapath produces by comparing two registers. From these it picks one of three addresses: the next sequential halfword, a PC-relative branch target, or a region-local jump target.

Instructions are 16 bits wide, so every address the block produces is halfword aligned. Branch targets are measured from the address that follows the branch, with the offset counted in halfwords. A jump keeps the 8 KiB region given by the three top PC bits and replaces the low bits with the offset counted in halfwords. Instruction memory and the register comparison are outside this block.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_ni` is low the PC is 0x0000. The reset is asynchronous and takes effect at once.
- R2: Opcodes 0 to 10, 14 and 15 are not control flow. For these the PC becomes PC + 2 at the next rising edge.
- R3: Opcode 11 is branch-if-equal. With `equal_i` = 1 the PC becomes PC + 2 + 2 × offset at the next rising edge.
- R4: Opcode 12 is branch-if-not-equal. With `equal_i` = 0 the PC becomes PC + 2 + 2 × offset at the next rising edge.
- R5: A branch that is not taken advances the PC by 2. This is opcode 11 with `equal_i` = 0, or opcode 12 with `equal_i` = 1.
- R6: Opcode 13 is jump. The next PC is the current PC[15:13], then the 12-bit jump offset, then a zero in bit 0. The top bits come from the current PC, not from PC + 2.
- R7: The branch offset is a two's-complement value. Its most significant bit is sign-extended, so negative offsets branch backward.
- R8: All address arithmetic wraps modulo 2^16. For example, sequential flow from 0xFFFE gives 0x0000.
- R9: Bit 0 of the PC is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the PC updates on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 4 | Opcode of the current instruction |
| equal_i | input | 1 | High when the two compared registers are equal |
| br_off_i | input | 6 | Signed branch offset, counted in halfwords |
| jmp_off_i | input | 12 | Jump offset, counted in halfwords |
| pc_o | output | 16 | Registered program counter |

## Verification
Every result is due exactly one rising edge after the inputs that cause it, because the PC register is the only register on the path. The exception is reset, which acts on `pc_o` at once. The bench applies each input set after an edge. It advances its own model at the next edge and samples `pc_o` one time unit after that edge, so no comparison falls on the active edge. The assertions use the same one-edge timing through `|=>` and `$past`.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned OP_W = 4;

  // opcode values decoded by this unit
  localparam logic [OP_W-1:0] OP_BR_EQ = 4'd11;
  localparam logic [OP_W-1:0] OP_BR_NE = 4'd12;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd13;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JUMP = 2'd2
  } next_sel_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            equal_i,
  output next_sel_e       sel_o
);
  always_comb begin
    unique case (op_i)
      OP_BR_EQ: sel_o = equal_i  ? SEL_BR : SEL_SEQ;
      OP_BR_NE: sel_o = !equal_i ? SEL_BR : SEL_SEQ;
      OP_JUMP:  sel_o = SEL_JUMP;
      default:  sel_o = SEL_SEQ;
    endcase
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned BR_OFF_W = 6,
  parameter int unsigned KEEP_W   = 3,
  localparam int unsigned JMP_W   = PC_W - KEEP_W - 1
) (
  input  logic [PC_W-1:0]     pc_i,
  input  logic [BR_OFF_W-1:0] br_off_i,
  input  logic [JMP_W-1:0]    jmp_off_i,
  output logic [PC_W-1:0]     seq_o,
  output logic [PC_W-1:0]     br_o,
  output logic [PC_W-1:0]     jmp_o
);
  localparam int unsigned EXT_W = PC_W - BR_OFF_W;

  logic [PC_W-1:0] br_ext;

  assign seq_o  = pc_i + PC_W'(2);
  assign br_ext = {{EXT_W{br_off_i[BR_OFF_W-1]}}, br_off_i};
  assign br_o   = seq_o + (br_ext << 1);
  // region bits from the current pc, not from pc + 2
  assign jmp_o  = {pc_i[PC_W-1 -: KEEP_W], jmp_off_i, 1'b0};
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned BR_OFF_W = 6,
  parameter int unsigned KEEP_W   = 3,
  localparam int unsigned JMP_W   = PC_W - KEEP_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic                equal_i,
  input  logic [BR_OFF_W-1:0] br_off_i,
  input  logic [JMP_W-1:0]    jmp_off_i,
  output logic [PC_W-1:0]     pc_o
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] seq_addr, br_addr, jmp_addr;
  next_sel_e       sel;

  pcu_decode u_decode (
    .op_i    (opcode_i),
    .equal_i (equal_i),
    .sel_o   (sel)
  );

  pcu_target #(
    .PC_W     (PC_W),
    .BR_OFF_W (BR_OFF_W),
    .KEEP_W   (KEEP_W)
  ) u_target (
    .pc_i      (pc_q),
    .br_off_i  (br_off_i),
    .jmp_off_i (jmp_off_i),
    .seq_o     (seq_addr),
    .br_o      (br_addr),
    .jmp_o     (jmp_addr)
  );

  always_comb begin
    unique case (sel)
      SEL_BR:   pc_d = br_addr;
      SEL_JUMP: pc_d = jmp_addr;
      default:  pc_d = seq_addr;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> pc_o == '0);

  // R2 R5 R8
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i != OP_JUMP &&
     !(opcode_i == OP_BR_EQ && equal_i) && !(opcode_i == OP_BR_NE && !equal_i))
    |=> pc_o == $past(pc_o) + PC_W'(2));

  // R3 R4 R7
  br_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((opcode_i == OP_BR_EQ && equal_i) || (opcode_i == OP_BR_NE && !equal_i))
    |=> $signed(pc_o - $past(pc_o) - PC_W'(2)) == PC_W'($signed($past(br_off_i)) * 2));

  // R6
  jmp_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_i == OP_JUMP
    |=> pc_o[PC_W-1 -: KEEP_W] == $past(pc_o[PC_W-1 -: KEEP_W]) &&
        pc_o[PC_W-KEEP_W-1:1] == $past(jmp_off_i));

  // R9
  pc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pc_o[0] == 1'b0);
endmodule

// File: tb/pc_next_unit_test.sv
`timescale 1ns/1ps
module pc_next_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd2;
  logic        eq = 1'b0;
  logic [5:0]  boff = '0;
  logic [11:0] joff = '0;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  int model_pc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pc_next_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(op), .equal_i(eq),
    .br_off_i(boff), .jmp_off_i(joff), .pc_o(pc)
  );

  function automatic int ref_next(int cur, int o, int bo, int jo, bit e);
    int s;
    s = (bo >= 32) ? bo - 64 : bo;
    if ((o == 11 && e) || (o == 12 && !e)) return (cur + 2 + s * 2) & 32'hFFFF;
    if (o == 13) return (cur & 32'hE000) | (jo * 2);
    return (cur + 2) & 32'hFFFF;
  endfunction

  function automatic string auto_tag(int o, int bo, bit e);
    if (o == 13) return "R6";
    if (o == 11 && e)  return (bo >= 32) ? "R7" : "R3";
    if (o == 12 && !e) return (bo >= 32) ? "R7" : "R4";
    if (o == 11 || o == 12) return "R5";
    return "R2";
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (int'(pc) != exp) begin
      errors++;
      $display("FAIL %s: pc_o=%04h expected=%04h", tag, pc, exp[15:0]);
    end
  endtask

  task automatic step(int o, int bo, int jo, bit e, string tag = "");
    op = o[3:0]; boff = bo[5:0]; joff = jo[11:0]; eq = e;
    @(posedge clk);
    model_pc = ref_next(model_pc, o, bo, jo, e);
    #1;
    check(tag == "" ? auto_tag(o, bo, e) : tag, model_pc);
  endtask

  initial begin
    #3;
    check("R1", 0);
    @(posedge clk); #1 rst_n = 1'b1;
    model_pc = 0;
    // R2 sequential across several opcodes
    for (int i = 0; i <= 10; i++) step(i, 5, 0, 1'b1);
    step(14, 3, 7, 1'b0);
    step(15, 0, 0, 1'b1);
    // R3 taken forward, R5 untaken
    step(11, 6, 0, 1'b1);
    step(11, 6, 0, 1'b0);
    // R4 taken, R5 untaken
    step(12, 31, 0, 1'b0);
    step(12, 31, 0, 1'b1);
    // R7 backward branches
    step(11, 6'h3F, 0, 1'b1);
    step(12, 6'h20, 0, 1'b0);
    // R6 jump within region
    step(13, 0, 12'h123, 1'b0);
    // reach top region: branch backward from 0 after reset
    rst_n = 1'b0; #1; model_pc = 0; check("R1", 0);
    @(negedge clk); rst_n = 1'b1;
    step(11, 6'h20, 0, 1'b1, "R8");      // 0 + 2 - 64 wraps to 0xFFC2
    step(13, 0, 12'hFFF, 1'b1, "R6");    // keeps 111, lands on 0xFFFE
    step(2, 0, 0, 1'b0, "R8");           // wraps to 0x0000
    step(13, 0, 12'hABC, 1'b0, "R6");    // region 000 from current pc
    // randomized run
    for (int i = 0; i < 300; i++) begin
      step(int'($urandom_range(15)), int'($urandom_range(63)),
           int'($urandom_range(4095)), 1'($urandom_range(1)));
      checks++;
      if (pc[0] !== 1'b0) begin
        errors++;
        $display("FAIL R9: pc_o[0]=%0b expected=0", pc[0]);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule